// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block walks a PLL through a safe change of its feedback multiplier without software stepping each register access. A single start pulse carries the already-encoded multiplier word. The sequencer then drives a simple register bus toward the PLL's register group. It first reads the current control word. It then shuts the PLL down with its bypass, input/output pass-through and output gate forced off. Next it loads the multiplier, sets both the input and output dividers to unity, and restarts the PLL. Finally it polls the lock flag a bounded number of times, with a programmable pause before each poll.

When a poll shows lock, the output gate is turned on and a one-cycle done pulse is raised. If every poll comes back unlocked, the gate is left off and a one-cycle fail pulse is raised. The register group is addressed relative to a base parameter, so one design serves every PLL instance that shares the layout. The pause length is given in clock cycles.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset the block is idle: busy_o, done_o, fail_o, bus_wr_o and bus_rd_o are all low.
- R2: A start pulse while idle causes one read of the control register (BASE_ADDR+4). It is followed by a write to that register of the value read with bit 0 (power-down) set and bits 1 to 4 (bypass, direct input, direct output, output gate) cleared.
- R3: The write right after the power-down write goes to the multiplier register (BASE_ADDR+8). It carries the multiplier word latched with the start pulse.
- R4: The next write goes to the divider register (BASE_ADDR+12) with the value 0x00302062, which selects divide-by-one before and after the PLL.
- R5: The next write goes to control and carries the power-down value with only bit 0 cleared.
- R6: The first read of the status register (BASE_ADDR+0) comes WAIT_CYCLES+1 cycles after the power-up write. Each later status read comes WAIT_CYCLES+2 cycles after the previous one.
- R7: Only bit 0 of the status word is taken as the lock flag. On the first status read that shows it set, polling stops. Control is then written with the power-up value plus bit 4 (output gate), and done_o pulses for one cycle on the cycle after that write.
- R8: If MAX_POLLS status reads all show bit 0 clear, exactly MAX_POLLS reads are made and no output-gate write occurs. fail_o pulses for one cycle, two cycles after the last read.
- R9: busy_o rises on the cycle after the start pulse, stays high through the done or fail pulse, and falls after it. A start pulse while busy_o is high changes neither the multiplier written nor the number of sequences run.
- R10: Each cycle carries at most one bus access (read or write), and done_o and fail_o never rise together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, one cycle |
| mult_word_i | input | DATA_W | Encoded multiplier word, taken with start |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle success pulse |
| fail_o | output | 1 | One-cycle no-lock pulse |
| bus_wr_o | output | 1 | Register write strobe |
| bus_rd_o | output | 1 | Register read strobe |
| bus_addr_o | output | ADDR_W | Register byte address |
| bus_wdata_o | output | DATA_W | Write data |
| bus_rdata_i | input | DATA_W | Read data, valid from the cycle after the read strobe until the next read |

## Verification
The bench builds the block with BASE_ADDR at 0x2C, which is the second PLL's layout, so the address arithmetic on the base is exercised rather than a zero offset. WAIT_CYCLES is 6, so a full four-poll ladder ends in a few dozen cycles. This lets exact pause spacing, lock on each poll position from first to last, and the no-lock failure all be checked in cycle-accurate detail. MAX_POLLS stays at 4, so the boundary between locking on the last poll and failing is hit directly.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    // control word bit positions
    localparam int CTL_PWRDN  = 0;
    localparam int CTL_BYPASS = 1;
    localparam int CTL_DIRIN  = 2;
    localparam int CTL_DIROUT = 3;
    localparam int CTL_OUTEN  = 4;

    // status word bit position of the lock flag
    localparam int STAT_LOCK = 0;

    // register offsets from the group base
    localparam int OFS_STAT = 0;
    localparam int OFS_CTRL = 4;
    localparam int OFS_MULT = 8;
    localparam int OFS_DIVS = 12;

    // divider word that selects unity pre and post division
    localparam logic [31:0] DIVS_UNITY = 32'h0030_2062;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_RDCTL,
        SQ_CAPCTL,
        SQ_PWRDN,
        SQ_MULT,
        SQ_DIVS,
        SQ_PWRUP,
        SQ_PAUSE,
        SQ_POLL,
        SQ_TEST,
        SQ_OUTEN,
        SQ_DONE,
        SQ_FAIL
    } seq_state_e;

endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
    parameter int WAIT_CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);
    localparam int CW = $clog2(WAIT_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          run;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.cnt = CW'(WAIT_CYCLES - 1);
            tmr_d.run = 1'b1;
        end else if (tmr_q.run) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.run = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign expired_o = tmr_q.run && (tmr_q.cnt == '0);

endmodule

// File: rtl/pll_seq_ctlfmt.sv
module pll_seq_ctlfmt
    import pll_seq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] cur_i,
    output logic [DATA_W-1:0] pwrdn_o,
    output logic [DATA_W-1:0] pwrup_o,
    output logic [DATA_W-1:0] outen_o
);
    always_comb begin
        pwrdn_o             = cur_i;
        pwrdn_o[CTL_PWRDN]  = 1'b1;
        pwrdn_o[CTL_BYPASS] = 1'b0;
        pwrdn_o[CTL_DIRIN]  = 1'b0;
        pwrdn_o[CTL_DIROUT] = 1'b0;
        pwrdn_o[CTL_OUTEN]  = 1'b0;

        pwrup_o             = cur_i;
        pwrup_o[CTL_PWRDN]  = 1'b0;

        outen_o             = cur_i;
        outen_o[CTL_OUTEN]  = 1'b1;
    end

endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
    import pll_seq_pkg::*;
#(
    parameter int              ADDR_W      = 8,
    parameter int              DATA_W      = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h1C,
    parameter int              WAIT_CYCLES = 500,
    parameter int              MAX_POLLS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] mult_word_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              fail_o,
    output logic              bus_wr_o,
    output logic              bus_rd_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic [DATA_W-1:0] bus_rdata_i
);
    localparam int PW = $clog2(MAX_POLLS + 1);
    localparam logic [ADDR_W-1:0] A_STAT = BASE_ADDR + ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_CTRL = BASE_ADDR + ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_MULT = BASE_ADDR + ADDR_W'(OFS_MULT);
    localparam logic [ADDR_W-1:0] A_DIVS = BASE_ADDR + ADDR_W'(OFS_DIVS);
    localparam logic [DATA_W-1:0] DIVS_W = DATA_W'(DIVS_UNITY);

    typedef struct packed {
        seq_state_e        st;
        logic [DATA_W-1:0] ctl;
        logic [DATA_W-1:0] mult;
        logic [PW-1:0]     polls;
    } seq_t;

    seq_t sq_d, sq_q;

    logic              tmr_load;
    logic              tmr_expired;
    logic [DATA_W-1:0] w_pwrdn;
    logic [DATA_W-1:0] w_pwrup;
    logic [DATA_W-1:0] w_outen;

    pll_seq_timer #(
        .WAIT_CYCLES(WAIT_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (tmr_load),
        .expired_o(tmr_expired)
    );

    pll_seq_ctlfmt #(
        .DATA_W(DATA_W)
    ) u_fmt (
        .cur_i  (sq_q.ctl),
        .pwrdn_o(w_pwrdn),
        .pwrup_o(w_pwrup),
        .outen_o(w_outen)
    );

    // next-state logic
    always_comb begin
        sq_d     = sq_q;
        tmr_load = 1'b0;
        unique case (sq_q.st)
            SQ_IDLE: begin
                if (start_i) begin
                    sq_d.st    = SQ_RDCTL;
                    sq_d.mult  = mult_word_i;
                    sq_d.polls = '0;
                end
            end
            SQ_RDCTL:  sq_d.st = SQ_CAPCTL;
            SQ_CAPCTL: begin
                sq_d.ctl = bus_rdata_i;
                sq_d.st  = SQ_PWRDN;
            end
            SQ_PWRDN: begin
                sq_d.ctl = w_pwrdn;
                sq_d.st  = SQ_MULT;
            end
            SQ_MULT:   sq_d.st = SQ_DIVS;
            SQ_DIVS:   sq_d.st = SQ_PWRUP;
            SQ_PWRUP: begin
                sq_d.ctl = w_pwrup;
                tmr_load = 1'b1;
                sq_d.st  = SQ_PAUSE;
            end
            SQ_PAUSE: begin
                if (tmr_expired) begin
                    sq_d.st = SQ_POLL;
                end
            end
            SQ_POLL: begin
                sq_d.polls = sq_q.polls + PW'(1);
                sq_d.st    = SQ_TEST;
            end
            SQ_TEST: begin
                if (bus_rdata_i[STAT_LOCK]) begin
                    sq_d.st = SQ_OUTEN;
                end else if (sq_q.polls == PW'(MAX_POLLS)) begin
                    sq_d.st = SQ_FAIL;
                end else begin
                    tmr_load = 1'b1;
                    sq_d.st  = SQ_PAUSE;
                end
            end
            SQ_OUTEN: begin
                sq_d.ctl = w_outen;
                sq_d.st  = SQ_DONE;
            end
            SQ_DONE:   sq_d.st = SQ_IDLE;
            SQ_FAIL:   sq_d.st = SQ_IDLE;
            default:   sq_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q <= '{st: SQ_IDLE, ctl: '0, mult: '0, polls: '0};
        end else begin
            sq_q <= sq_d;
        end
    end

    // bus and status outputs decoded from the registered state
    always_comb begin
        bus_wr_o    = 1'b0;
        bus_rd_o    = 1'b0;
        bus_addr_o  = '0;
        bus_wdata_o = '0;
        unique case (sq_q.st)
            SQ_RDCTL: begin
                bus_rd_o   = 1'b1;
                bus_addr_o = A_CTRL;
            end
            SQ_PWRDN: begin
                bus_wr_o    = 1'b1;
                bus_addr_o  = A_CTRL;
                bus_wdata_o = w_pwrdn;
            end
            SQ_MULT: begin
                bus_wr_o    = 1'b1;
                bus_addr_o  = A_MULT;
                bus_wdata_o = sq_q.mult;
            end
            SQ_DIVS: begin
                bus_wr_o    = 1'b1;
                bus_addr_o  = A_DIVS;
                bus_wdata_o = DIVS_W;
            end
            SQ_PWRUP: begin
                bus_wr_o    = 1'b1;
                bus_addr_o  = A_CTRL;
                bus_wdata_o = w_pwrup;
            end
            SQ_POLL: begin
                bus_rd_o   = 1'b1;
                bus_addr_o = A_STAT;
            end
            SQ_OUTEN: begin
                bus_wr_o    = 1'b1;
                bus_addr_o  = A_CTRL;
                bus_wdata_o = w_outen;
            end
            default: ;
        endcase
    end

    assign busy_o = (sq_q.st != SQ_IDLE);
    assign done_o = (sq_q.st == SQ_DONE);
    assign fail_o = (sq_q.st == SQ_FAIL);

endmodule

// File: rtl/pll_reprog_seq_chk.sv
module pll_reprog_seq_chk #(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h1C
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              fail_o,
    input logic              bus_wr_o,
    input logic              bus_rd_o,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic [DATA_W-1:0] bus_wdata_o
);
    localparam logic [ADDR_W-1:0] C_STAT = BASE_ADDR;
    localparam logic [ADDR_W-1:0] C_CTRL = BASE_ADDR + ADDR_W'(4);
    localparam logic [ADDR_W-1:0] C_MULT = BASE_ADDR + ADDR_W'(8);
    localparam logic [ADDR_W-1:0] C_DIVS = BASE_ADDR + ADDR_W'(12);

    a_r10_single_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_o && bus_rd_o));

    a_r10_pulse_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o));

    a_r9_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    a_r9_idle_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || fail_o) |=> !busy_o);

    a_r3_mult_after_pwrdn: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_o && bus_addr_o == C_MULT) |->
            ($past(bus_wr_o) && $past(bus_addr_o) == C_CTRL && $past(bus_wdata_o[0])));

    a_r4_divs_after_mult: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_o && bus_addr_o == C_DIVS) |->
            ($past(bus_wr_o) && $past(bus_addr_o) == C_MULT));

    a_r7_done_after_outen: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(bus_wr_o) && $past(bus_addr_o) == C_CTRL && $past(bus_wdata_o[4])));

    a_r8_fail_after_poll: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> ($past(bus_rd_o, 2) && $past(bus_addr_o, 2) == C_STAT));

endmodule

bind pll_reprog_seq pll_reprog_seq_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .BASE_ADDR(BASE_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .fail_o     (fail_o),
    .bus_wr_o   (bus_wr_o),
    .bus_rd_o   (bus_rd_o),
    .bus_addr_o (bus_addr_o),
    .bus_wdata_o(bus_wdata_o)
);

// File: tb/pll_reprog_seq_tb.sv
module pll_reprog_seq_tb;
    localparam int          AW    = 8;
    localparam int          DW    = 32;
    localparam logic [7:0]  BASE  = 8'h2C;
    localparam int          WAITC = 6;
    localparam int          MAXP  = 4;
    localparam logic [7:0]  A_ST  = BASE;
    localparam logic [7:0]  A_CT  = BASE + 8'd4;
    localparam logic [7:0]  A_MU  = BASE + 8'd8;
    localparam logic [7:0]  A_DV  = BASE + 8'd12;
    localparam int          NV    = 6;

    localparam logic [31:0] V_CTL [NV] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_001E,
                                           32'h5A5A_A5A5, 32'h0000_0010, 32'h0300_0001};
    localparam logic [31:0] V_MUL [NV] = '{32'h0B21_4000, 32'h0003_1234, 32'h07FF_FFFF,
                                           32'h0000_0000, 32'h1234_5678, 32'hFFFF_FFFF};
    localparam int          V_LCK [NV] = '{0, 1, 2, 3, 4, 9};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [DW-1:0] mult_word_i = '0;
    logic          busy_o, done_o, fail_o, bus_wr_o, bus_rd_o;
    logic [AW-1:0] bus_addr_o;
    logic [DW-1:0] bus_wdata_o;
    logic [DW-1:0] bus_rdata_i = '0;

    always #10 clk = ~clk;

    pll_reprog_seq #(
        .ADDR_W(AW), .DATA_W(DW), .BASE_ADDR(BASE),
        .WAIT_CYCLES(WAITC), .MAX_POLLS(MAXP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mult_word_i(mult_word_i),
        .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
        .bus_wr_o(bus_wr_o), .bus_rd_o(bus_rd_o), .bus_addr_o(bus_addr_o),
        .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i)
    );

    int n_chk = 0;
    int n_fail = 0;

    // register model and bus monitor
    int          cyc = 0;
    logic [31:0] ctl_reg = '0;
    int          lock_at = 0;
    int          nw = 0, nr = 0, nrc = 0, ndone = 0, nfail = 0;
    int          done_c = 0, fail_c = 0;
    logic        busy_at_pulse = 1'b0;
    logic [7:0]  wl_a [16];
    logic [31:0] wl_d [16];
    int          wl_c [16];
    int          rl_c [16];

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (bus_wr_o) begin
            if (nw < 16) begin
                wl_a[nw] = bus_addr_o;
                wl_d[nw] = bus_wdata_o;
                wl_c[nw] = cyc;
            end
            nw = nw + 1;
            if (bus_addr_o == A_CT) ctl_reg = bus_wdata_o;
        end
        if (bus_rd_o) begin
            if (bus_addr_o == A_ST) begin
                if (nr < 16) rl_c[nr] = cyc;
                bus_rdata_i <= 32'hFFFF_FFFE | {31'd0, (nr >= lock_at)};
                nr = nr + 1;
            end else begin
                bus_rdata_i <= ctl_reg;
                nrc = nrc + 1;
            end
        end
        if (done_o) begin ndone = ndone + 1; done_c = cyc; busy_at_pulse = busy_o; end
        if (fail_o) begin nfail = nfail + 1; fail_c = cyc; busy_at_pulse = busy_o; end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    // watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 100000) begin
            n_chk = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog actual=%h expected=%h", wd, 100000);
            finish_run();
        end
    end

    task automatic run_case(input logic [31:0] ictl, input logic [31:0] mul,
                            input int lk, input bit poke);
        logic [31:0] e_pd, e_pu, e_en;
        bit          ok_end;
        int          exp_w, exp_r;
        @(negedge clk);
        ctl_reg = ictl; lock_at = lk;
        nw = 0; nr = 0; nrc = 0; ndone = 0; nfail = 0;
        e_pd  = (ictl | 32'h1) & ~32'h1E;
        e_pu  = e_pd & ~32'h1;
        e_en  = e_pu | 32'h10;
        exp_w = (lk < MAXP) ? 5 : 4;
        exp_r = (lk < MAXP) ? lk + 1 : MAXP;
        start_i = 1'b1; mult_word_i = mul;
        @(negedge clk);
        start_i = 1'b0; mult_word_i = ~mul;
        chk(busy_o == 1'b1, "R9 busy after start", {31'd0, busy_o}, 32'd1);
        if (poke) begin
            repeat (4) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        for (int i = 0; i < 300 && (ndone + nfail) == 0; i++) @(negedge clk);
        ok_end = (ndone + nfail) == 1;
        chk(ok_end, "R9 one sequence end", ndone + nfail, 1);
        repeat (20) @(negedge clk);
        chk(busy_o == 1'b0, "R9 busy low after pulse", {31'd0, busy_o}, 32'd0);
        chk(busy_at_pulse == 1'b1, "R9 busy during pulse", {31'd0, busy_at_pulse}, 32'd1);
        chk(ndone + nfail == 1, "R9 no second sequence", ndone + nfail, 1);
        chk(nrc == 1, "R2 control read count", nrc, 1);
        chk(nw == exp_w, "R7 R8 write count", nw, exp_w);
        if (nw >= 4) begin
            chk(wl_a[0] == A_CT && wl_d[0] == e_pd, "R2 power-down write", wl_d[0], e_pd);
            chk(wl_a[1] == A_MU && wl_d[1] == mul && wl_c[1] == wl_c[0] + 1,
                "R3 multiplier write", wl_d[1], mul);
            chk(wl_a[2] == A_DV && wl_d[2] == 32'h0030_2062 && wl_c[2] == wl_c[1] + 1,
                "R4 divider write", wl_d[2], 32'h0030_2062);
            chk(wl_a[3] == A_CT && wl_d[3] == e_pu && wl_c[3] == wl_c[2] + 1,
                "R5 power-up write", wl_d[3], e_pu);
        end
        chk(nr == exp_r, "R7 R8 status read count", nr, exp_r);
        if (nr >= 1 && nw >= 4)
            chk(rl_c[0] - wl_c[3] == WAITC + 1, "R6 first poll spacing", rl_c[0] - wl_c[3], WAITC + 1);
        for (int i = 1; i < nr && i < 16; i++)
            chk(rl_c[i] - rl_c[i-1] == WAITC + 2, "R6 poll spacing", rl_c[i] - rl_c[i-1], WAITC + 2);
        if (lk < MAXP) begin
            chk(ndone == 1 && nfail == 0, "R7 done pulse", ndone, 1);
            if (nw == 5) begin
                chk(wl_a[4] == A_CT && wl_d[4] == e_en, "R7 output-enable write", wl_d[4], e_en);
                chk(done_c == wl_c[4] + 1, "R7 done timing", done_c, wl_c[4] + 1);
            end
            chk(ctl_reg == e_en, "R7 final control", ctl_reg, e_en);
        end else begin
            chk(nfail == 1 && ndone == 0, "R8 fail pulse", nfail, 1);
            if (nr == MAXP)
                chk(fail_c == rl_c[MAXP-1] + 2, "R8 fail timing", fail_c, rl_c[MAXP-1] + 2);
            chk(ctl_reg == e_pu, "R8 gate stays off", ctl_reg, e_pu);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({busy_o, done_o, fail_o, bus_wr_o, bus_rd_o} == 5'b0, "R1 reset idle",
            {27'd0, busy_o, done_o, fail_o, bus_wr_o, bus_rd_o}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({busy_o, done_o, fail_o, bus_wr_o, bus_rd_o} == 5'b0, "R1 idle after release",
            {27'd0, busy_o, done_o, fail_o, bus_wr_o, bus_rd_o}, 32'd0);
        for (int v = 0; v < NV; v++) run_case(V_CTL[v], V_MUL[v], V_LCK[v], 1'b0);
        // R9 start while busy is ignored
        run_case(32'h0000_001F, 32'hCAFE_0001, 2, 1'b1);
        run_case(32'h8000_0002, 32'h0101_0101, 5, 1'b1);
        finish_run();
    end

endmodule